// File: doc/BRIEF.md
# Regulator Power-Up Soft-Start Sequencer

This block is the digital supervisor of a multiphase buck regulator controller. It watches three already-qualified enable conditions: bias supply good, a power-rail enable and a termination-rail enable. It also watches a 6-bit voltage identification (VID) code. When all enables are present and the code asks for a real voltage, it runs a fixed start-up delay. It then raises an internal DAC target, counted in 6.25 mV steps, by one step per soft-start oscillator tick until the target for that code is reached. Power-good is then reported whenever the externally judged regulation window is met.

Two VID codes request "off". If one is present at the moment of enabling, the regulator locks itself off until an enable or the bias supply is recycled. If one arrives while the regulator is ramping or running, the PWM keeps switching for two more PWM cycles. The block then disables the PWM and selects the shutdown overvoltage trip level. A separate overvoltage fault input latches a shutdown that only loss of bias clears. The off codes have no path that clears that latch. The analog comparators, the DAC, the oscillator and the PWM modulator sit outside and are seen only as digital strobes and levels.

Top module: `ss_sequencer`

## Requirements
- R1: After reset, or with any enable low, the outputs are: pwm_enable 0, pwm_tristate 1, ov_trip_shutdown 0 (unless R11 latched), power_good 0 and dac_steps 0.
- R2: With por_ok, pwr_en and vtt_en all high and a non-off VID, pwm_enable rises exactly TD1_CYCLES+1 clock edges after the edge at which the last enable was first seen high. pwm_enable stays low before that.
- R3: During the ramp, dac_steps grows by exactly one on each clock edge at which ss_tick is high, and holds on edges where ss_tick is low.
- R4: The ramp target is MAX_STEPS − VID×STEPS_PER_CODE, with VID read as an unsigned number in 0..61. dac_steps stops at that value.
- R5: One edge after dac_steps equals the target, the block is in regulation. From then on power_good equals in_window; at all other times power_good is 0.
- R6: pwm_tristate is always the inverse of pwm_enable.
- R7: The off codes are 6'b111111 and 6'b111110. If all enables become high while an off code is present, the block stays off (pwm_enable 0), even if the VID later turns valid.
- R8: The lock-off of R7 is released only by taking por_ok, pwr_en or vtt_en low. A later full enable with a valid VID then starts normally.
- R9: An off code that appears while ramping or regulating keeps pwm_enable high until the second pwm_cycle strobe. At that edge, pwm_enable falls and ov_trip_shutdown rises, and both stay that way while the enables remain high.
- R10: When any enable input drops, the next clock edge gives pwm_enable 0, pwm_tristate 1, dac_steps 0 and power_good 0.
- R11: ov_fault high at an edge (with por_ok high) gives pwm_enable 0 and ov_trip_shutdown 1 from that edge on. Enable toggles and off codes do not clear this state; only por_ok low clears it.
- R12: In regulation, a VID change moves dac_steps toward the new target by one step per ss_tick, downward or upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| pwr_en | input | 1 | Power-rail enable comparator output |
| vtt_en | input | 1 | Termination-rail enable comparator output |
| vid | input | 6 | Voltage identification code |
| ss_tick | input | 1 | Soft-start oscillator tick, one clock wide per step |
| pwm_cycle | input | 1 | Strobe once per PWM switching cycle |
| in_window | input | 1 | Output voltage inside its regulation window |
| ov_fault | input | 1 | Overvoltage comparator trip |
| pwm_enable | output | 1 | PWM switching enabled |
| pwm_tristate | output | 1 | Hold PWM outputs high-impedance |
| ov_trip_shutdown | output | 1 | Select the shutdown overvoltage trip level |
| power_good | output | 1 | Output in regulation after soft-start |
| dac_steps | output | DAC_W | DAC target in 6.25 mV steps |

## Verification
The bench builds the block with TD1_CYCLES=5, MAX_STEPS=130, STEPS_PER_CODE=2 and DAC_W=8. With these values the start-up delay is short and every valid VID code gives a ramp of 8 to 130 steps. A full power-up can then be run for all 62 valid codes, checking the delay edge, the final step count and the power-good edge against arithmetic in the bench. The same small configuration keeps both off codes, the two-strobe shutdown, the fault latch and the enable-loss cases within a few thousand cycles.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    localparam int VID_W = 6;

    typedef enum logic [2:0] {
        ST_SHUT,
        ST_DELAY,
        ST_RAMP,
        ST_RUN,
        ST_OFF_WAIT,
        ST_OFF_DONE,
        ST_LOCK_OFF,
        ST_OV
    } seq_state_e;

    typedef struct packed {
        logic pwm_on;
        logic trip_sd;
        logic dac_keep;
    } seq_ctl_t;

    // The two highest codes request the regulator to be off.
    function automatic logic is_off_code(input logic [VID_W-1:0] code);
        return code[VID_W-1:1] == {(VID_W-1){1'b1}};
    endfunction

    // Linear code-to-target map: code 0 is the highest target.
    function automatic int vid_to_steps(input logic [VID_W-1:0] code,
                                        input int max_steps,
                                        input int per_code);
        return max_steps - int'(code) * per_code;
    endfunction

    function automatic seq_ctl_t decode_state(input seq_state_e st);
        seq_ctl_t c;
        c.pwm_on   = (st == ST_RAMP) || (st == ST_RUN) || (st == ST_OFF_WAIT);
        c.trip_sd  = (st == ST_OFF_DONE);
        c.dac_keep = c.pwm_on;
        return c;
    endfunction

endpackage

// File: rtl/ss_td1_timer.sv
module ss_td1_timer #(
    parameter int CYCLES = 136000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/ss_dac_ramp.sv
module ss_dac_ramp #(
    parameter int DAC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             track,
    input  logic             tick,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] dac
);
    logic [DAC_W-1:0] dac_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dac_q <= '0;
        end else if (track && tick) begin
            if (dac_q < target) begin
                dac_q <= dac_q + DAC_W'(1);
            end else if (dac_q > target) begin
                dac_q <= dac_q - DAC_W'(1);
            end
        end
    end

    assign dac = dac_q;

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (dac_q == $past(dac_q) ||
                  dac_q == $past(dac_q) + DAC_W'(1) ||
                  dac_q == $past(dac_q) - DAC_W'(1)));

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> (dac_q == $past(dac_q)));

endmodule

// File: rtl/ss_off_delay.sv
module ss_off_delay #(
    parameter int STROBES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic strobe,
    output logic done
);
    localparam int OW = $clog2(STROBES + 1);

    logic [OW-1:0] seen_q;

    assign done = arm && strobe && (seen_q == OW'(STROBES - 1));

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            seen_q <= '0;
        end else if (strobe && !done) begin
            seen_q <= seen_q + OW'(1);
        end
    end

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
    import ss_seq_pkg::*;
#(
    parameter int TD1_CYCLES     = 136000,
    parameter int MAX_STEPS      = 256,
    parameter int STEPS_PER_CODE = 2,
    parameter int OFF_STROBES    = 2,
    parameter int DAC_W          = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_ok,
    input  logic             pwr_en,
    input  logic             vtt_en,
    input  logic [5:0]       vid,
    input  logic             ss_tick,
    input  logic             pwm_cycle,
    input  logic             in_window,
    input  logic             ov_fault,
    output logic             pwm_enable,
    output logic             pwm_tristate,
    output logic             ov_trip_shutdown,
    output logic             power_good,
    output logic [DAC_W-1:0] dac_steps
);
    seq_state_e       state_q, state_d;
    seq_ctl_t         ctl_q, ctl_d;
    logic             en_all;
    logic             off_req;
    logic             ov_lat_q;
    logic             td1_done;
    logic             off_done;
    logic             dac_clr;
    logic             dac_track;
    logic [DAC_W-1:0] target;
    logic [DAC_W-1:0] dac_now;

    assign en_all  = por_ok && pwr_en && vtt_en;
    assign off_req = is_off_code(vid);
    assign target  = DAC_W'(vid_to_steps(vid, MAX_STEPS, STEPS_PER_CODE));

    // Overvoltage latch: set by the fault, cleared only by loss of bias.
    always_ff @(posedge clk) begin
        if (rst || !por_ok) begin
            ov_lat_q <= 1'b0;
        end else if (ov_fault) begin
            ov_lat_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en_all) begin
            state_d = ST_SHUT;
        end else if (ov_fault || ov_lat_q) begin
            state_d = ST_OV;
        end else begin
            unique case (state_q)
                ST_SHUT:     state_d = off_req ? ST_LOCK_OFF : ST_DELAY;
                ST_DELAY: begin
                    if (off_req)       state_d = ST_OFF_DONE;
                    else if (td1_done) state_d = ST_RAMP;
                end
                ST_RAMP: begin
                    if (off_req)                 state_d = ST_OFF_WAIT;
                    else if (dac_now == target)  state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (off_req) state_d = ST_OFF_WAIT;
                end
                ST_OFF_WAIT: begin
                    if (off_done) state_d = ST_OFF_DONE;
                end
                ST_OFF_DONE: state_d = ST_OFF_DONE;
                ST_LOCK_OFF: state_d = ST_LOCK_OFF;
                ST_OV:       state_d = ST_OV;
                default:     state_d = ST_SHUT;
            endcase
        end
    end

    always_comb begin
        ctl_d = decode_state(state_d);
        ctl_q = decode_state(state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    assign dac_clr   = !ctl_d.dac_keep;
    assign dac_track = ((state_q == ST_RAMP) || (state_q == ST_RUN)) &&
                       ((state_d == ST_RAMP) || (state_d == ST_RUN));

    ss_td1_timer #(
        .CYCLES (TD1_CYCLES)
    ) i_td1 (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_DELAY),
        .done (td1_done)
    );

    ss_dac_ramp #(
        .DAC_W (DAC_W)
    ) i_dac (
        .clk    (clk),
        .rst    (rst),
        .clr    (dac_clr),
        .track  (dac_track),
        .tick   (ss_tick),
        .target (target),
        .dac    (dac_now)
    );

    ss_off_delay #(
        .STROBES (OFF_STROBES)
    ) i_offd (
        .clk    (clk),
        .rst    (rst),
        .arm    (state_q == ST_OFF_WAIT),
        .strobe (pwm_cycle),
        .done   (off_done)
    );

    assign pwm_enable       = ctl_q.pwm_on;
    assign pwm_tristate     = !ctl_q.pwm_on;
    assign ov_trip_shutdown = ctl_q.trip_sd || ov_lat_q;
    assign power_good       = (state_q == ST_RUN) && in_window;
    assign dac_steps        = dac_now;

    // R10
    enable_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !en_all |=> (!pwm_enable && pwm_tristate && dac_steps == '0 && !power_good));

    // R11
    ov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ov_lat_q && por_ok) |=> (ov_lat_q && !pwm_enable && ov_trip_shutdown));

    // R7
    lock_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK_OFF && en_all && !ov_fault) |=>
            (state_q == ST_LOCK_OFF && !pwm_enable));

    // R5
    pg_qualify_chk: assert property (@(posedge clk) disable iff (rst)
        power_good |-> (pwm_enable && !ov_trip_shutdown && in_window));

    // R9
    off_wait_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF_WAIT && !pwm_cycle) |=> pwm_enable);

endmodule

// File: tb/test_ss_sequencer.sv
module test_ss_sequencer;

    localparam int TD1  = 5;
    localparam int MAXS = 130;
    localparam int PER  = 2;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          por_ok = 1'b0, pwr_en = 1'b0, vtt_en = 1'b0;
    logic [5:0]    vid = 6'd0;
    logic          ss_tick = 1'b1, pwm_cycle = 1'b0, in_window = 1'b1, ov_fault = 1'b0;
    logic          pwm_enable, pwm_tristate, ov_trip_shutdown, power_good;
    logic [DW-1:0] dac_steps;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ss_sequencer #(
        .TD1_CYCLES     (TD1),
        .MAX_STEPS      (MAXS),
        .STEPS_PER_CODE (PER),
        .OFF_STROBES    (2),
        .DAC_W          (DW)
    ) i_ss_sequencer (
        .clk              (clk),
        .rst              (rst),
        .por_ok           (por_ok),
        .pwr_en           (pwr_en),
        .vtt_en           (vtt_en),
        .vid              (vid),
        .ss_tick          (ss_tick),
        .pwm_cycle        (pwm_cycle),
        .in_window        (in_window),
        .ov_fault         (ov_fault),
        .pwm_enable       (pwm_enable),
        .pwm_tristate     (pwm_tristate),
        .ov_trip_shutdown (ov_trip_shutdown),
        .power_good       (power_good),
        .dac_steps        (dac_steps)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int tgt(input int v);
        return MAXS - v * PER;
    endfunction

    task automatic all_en(input logic v);
        por_ok = v; pwr_en = v; vtt_en = v;
    endtask

    // Enables go high now; returns after the block has reached regulation.
    task automatic power_up(input int v, input string tag);
        vid = 6'(v);
        all_en(1'b1);
        step(TD1);
        check({tag, " pwm low during delay"}, int'(pwm_enable), 0);
        step(1);
        check({tag, " pwm high after delay"}, int'(pwm_enable), 1);
        step(tgt(v));
        check({tag, " dac at target"}, int'(dac_steps), tgt(v));
        check({tag, " pg low while ramp ends"}, int'(power_good), 0);
        step(1);
        check({tag, " pg high in regulation"}, int'(power_good), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check("R1 pwm_enable", int'(pwm_enable), 0);
        check("R1 tristate", int'(pwm_tristate), 1);
        check("R1 trip", int'(ov_trip_shutdown), 0);
        check("R1 pg", int'(power_good), 0);
        check("R1 dac", int'(dac_steps), 0);

        // R2, R4, R5, R6: sweep every valid code
        for (int v = 0; v < 62; v++) begin
            all_en(1'b0);
            step(1);
            power_up(v, "R2 R4 R5 sweep");
            check("R6 tristate inverse", int'(pwm_tristate), 0);
        end

        // R5: window input gates power-good
        in_window = 1'b0;
        #1;
        check("R5 pg follows window low", int'(power_good), 0);
        in_window = 1'b1;
        #1;
        check("R5 pg follows window high", int'(power_good), 1);

        // R2: one missing enable keeps shutdown
        all_en(1'b0);
        step(1);
        vid = 6'd10; por_ok = 1'b1; pwr_en = 1'b1;
        step(TD1 + 4);
        check("R2 vtt missing keeps off", int'(pwm_enable), 0);

        // R12: tracking in regulation, both directions
        vtt_en = 1'b1;
        step(TD1 + 1 + tgt(10) + 1);
        check("R12 reached regulation", int'(power_good), 1);
        vid = 6'd11;
        step(1);
        check("R12 down one", int'(dac_steps), tgt(10) - 1);
        step(1);
        check("R12 down two", int'(dac_steps), tgt(11));
        step(2);
        check("R12 down holds", int'(dac_steps), tgt(11));
        vid = 6'd9;
        step(4);
        check("R12 up", int'(dac_steps), tgt(9));

        // R3: slow tick during ramp
        all_en(1'b0);
        step(1);
        vid = 6'd20; ss_tick = 1'b0;
        all_en(1'b1);
        step(TD1 + 1);
        step(3);
        check("R3 no tick holds", int'(dac_steps), 0);
        ss_tick = 1'b1;
        step(1);
        ss_tick = 1'b0;
        check("R3 one tick one step", int'(dac_steps), 1);
        step(2);
        check("R3 hold after tick", int'(dac_steps), 1);
        ss_tick = 1'b1;

        // R10: lose termination enable mid-ramp
        step(5);
        vtt_en = 1'b0;
        step(1);
        check("R10 dac cleared", int'(dac_steps), 0);
        check("R10 tristate", int'(pwm_tristate), 1);
        check("R10 pwm off", int'(pwm_enable), 0);
        check("R10 pg", int'(power_good), 0);

        // R7, R8: both off codes at enable lock the block off
        for (int k = 0; k < 2; k++) begin
            all_en(1'b0);
            step(1);
            vid = (k == 0) ? 6'b111111 : 6'b111110;
            all_en(1'b1);
            step(2);
            vid = 6'd30;
            step(TD1 + tgt(30) + 4);
            check("R7 locked off", int'(pwm_enable), 0);
            check("R7 locked dac", int'(dac_steps), 0);
            if (k == 0) pwr_en = 1'b0; else por_ok = 1'b0;
            step(1);
            if (k == 0) pwr_en = 1'b1; else por_ok = 1'b1;
            power_up(30, "R8 restart after recycle");
        end

        // R9: off code while regulating
        vid = 6'b111110;
        step(1);
        check("R9 still on after code", int'(pwm_enable), 1);
        pwm_cycle = 1'b1;
        step(1);
        pwm_cycle = 1'b0;
        check("R9 on after first strobe", int'(pwm_enable), 1);
        check("R9 trip normal first", int'(ov_trip_shutdown), 0);
        step(3);
        check("R9 on between strobes", int'(pwm_enable), 1);
        pwm_cycle = 1'b1;
        step(1);
        pwm_cycle = 1'b0;
        check("R9 off after second strobe", int'(pwm_enable), 0);
        check("R9 trip shutdown", int'(ov_trip_shutdown), 1);
        vid = 6'd5;
        step(TD1 + 10);
        check("R9 stays off", int'(pwm_enable), 0);
        check("R9 trip stays", int'(ov_trip_shutdown), 1);

        // R11: overvoltage latch
        all_en(1'b0);
        step(1);
        check("R9 trip released by enable loss", int'(ov_trip_shutdown), 0);
        power_up(40, "R11 pre-fault");
        ov_fault = 1'b1;
        step(1);
        ov_fault = 1'b0;
        check("R11 pwm off", int'(pwm_enable), 0);
        check("R11 trip", int'(ov_trip_shutdown), 1);
        pwr_en = 1'b0;
        step(1);
        pwr_en = 1'b1;
        vid = 6'b111111;
        step(2);
        vid = 6'd40;
        step(TD1 + tgt(40) + 4);
        check("R11 enable toggle keeps trip", int'(ov_trip_shutdown), 1);
        check("R11 enable toggle keeps off", int'(pwm_enable), 0);
        por_ok = 1'b0;
        step(1);
        check("R11 por clears trip", int'(ov_trip_shutdown), 0);
        por_ok = 1'b1;
        power_up(40, "R11 restart after por");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule